// File: doc/BRIEF.md
# Clock-Synchronous Block Serial Slave

This block is the slave end of a clock-synchronous serial link that trades fixed blocks of eight bytes with a master. The master supplies the serial clock. On each serial clock period the slave takes one bit from the receive line and drives one bit onto its transmit line, so a full block moves in both directions at once. The serial clock and receive data enter the system clock domain through two-flop synchronisers. All serial activity is detected as edges in that domain.

Block framing comes only from silence on the serial clock. A counter measures system clock cycles since the last serial clock edge. Once it reaches a programmable limit, the slave is armed, and the next rising edge becomes bit 0 of byte 0 of a new block. A partly received block is dropped when the line goes silent. After the 64th bit is captured, the slave pulses a done strobe and shows the whole received block at once. Any further serial clocks are then discarded until the line has been silent long enough again.

Top module: `blkser_slave`

## Requirements
- R1: After reset the slave is armed with its bit position at zero, `done_o` is 0, `rx_block_o` is all zeros, and `sdo_o` shows bit 0 of `tx_block_i` within a few system cycles.
- R2: Receive data is sampled on the rising serial clock edge. Bits arrive least significant first, byte 0 first. Received bit k of the block (byte k/8, bit k%8) lands at `rx_block_o[k]`.
- R3: Transmit data changes only on the falling serial clock edge, in the same bit order taken from `tx_block_i[k]`. Bit 0 is already on `sdo_o` while the slave is armed, before the first rising edge.
- R4: When the 64th bit is captured, `done_o` is high for exactly one system cycle. In that same cycle `rx_block_o` presents all 64 bits of the new block.
- R5: `rx_block_o` changes only in a cycle where `done_o` is high.
- R6: Serial clocks that arrive after a complete block and before a silence timeout have no effect: no done pulse, `rx_block_o` unchanged, `sdo_o` unchanged.
- R7: When no serial clock edge has occurred for `tmo_limit_i` system cycles, the slave re-arms. The next rising edge is then taken as bit 0 of a new block.
- R8: A pause in the serial clock that is shorter than the timeout keeps the current bit position, and the block completes normally.
- R9: A block cut short by a timeout is discarded: it gives no done pulse and does not alter `rx_block_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master (asynchronous) |
| sdi_i | input | 1 | Serial receive data from the master |
| sdo_o | output | 1 | Serial transmit data to the master |
| tmo_limit_i | input | TMO_W | Silence timeout in system clock cycles (at least 1) |
| tx_block_i | input | BYTES*BITS | Block to send, byte 0 in bits [7:0], LSB first |
| rx_block_o | output | BYTES*BITS | Last complete received block |
| done_o | output | 1 | One-cycle pulse when a block completes |

## Verification
The hardest state to reach is a serial clock that arrives during the dead time after a complete block, before the silence timeout runs out. A second such state is a block that is abandoned midway and then restarted. The bench reaches the first by running eight more serial clock periods straight after the 64th bit, with no pause, and then checking that the done count, the received block and the transmit line have not moved. It reaches the abandoned block by stopping the clock after 23 bits for longer than the limit and then sending a fresh block, which must arrive unshifted with only one done pulse. Pauses just short of the limit, and a reset in the middle of a block, cover the other side of the framing boundary.

// File: rtl/blkser_pkg.sv
package blkser_pkg;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_FULL   = 2'd2
    } blk_state_e;

    typedef struct packed {
        logic sc1;
        logic sc2;
        logic sc3;
        logic sd1;
        logic sd2;
    } sync_t;

endpackage

// File: rtl/blkser_sync.sv
module blkser_sync
    import blkser_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic rise_o,
    output logic fall_o,
    output logic sdi_o
);

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.sc1 = sclk_i;
        sync_d.sc2 = sync_q.sc1;
        sync_d.sc3 = sync_q.sc2;
        sync_d.sd1 = sdi_i;
        sync_d.sd2 = sync_q.sd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // data sampled at the same stage as the clock level used for edges
    assign rise_o = sync_q.sc2 & ~sync_q.sc3;
    assign fall_o = ~sync_q.sc2 & sync_q.sc3;
    assign sdi_o  = sync_q.sd2;

endmodule

// File: rtl/blkser_tmo.sv
module blkser_tmo #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (edge_i)                cnt_d = '0;
        else if (cnt_q < limit_i)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q >= limit_i);

endmodule

// File: rtl/blkser_core.sv
module blkser_core
    import blkser_pkg::*;
#(
    parameter int BYTES = 8,
    parameter int BITS  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rise_i,
    input  logic                   fall_i,
    input  logic                   sdi_i,
    input  logic                   expired_i,
    input  logic [BYTES*BITS-1:0]  tx_block_i,
    output logic                   sdo_o,
    output logic [BYTES*BITS-1:0]  rx_block_o,
    output logic                   done_o,
    output blk_state_e             state_o,
    output logic [$clog2(BYTES*BITS):0] bitcnt_o
);

    localparam int NBITS = BYTES * BITS;
    localparam int IDXW  = $clog2(NBITS);
    localparam int CNTW  = IDXW + 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(NBITS - 1);
    localparam logic [CNTW-1:0] FULLCNT = CNTW'(NBITS);

    typedef struct packed {
        blk_state_e        state;
        logic [CNTW-1:0]   bitcnt;
        logic [NBITS-1:0]  txsh;
        logic [NBITS-1:0]  rxsh;
        logic [NBITS-1:0]  rxout;
        logic              sdo;
        logic              done;
    } core_t;

    core_t c_d, c_q;
    logic  heading;

    assign heading = rise_i & ((c_q.state == ST_ARMED) | expired_i);

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        if (heading) begin
            c_d.rxsh    = '0;
            c_d.rxsh[0] = sdi_i;
            c_d.bitcnt  = CNTW'(1);
            c_d.state   = ST_ACTIVE;
        end else if (expired_i) begin
            c_d.state  = ST_ARMED;
            c_d.bitcnt = '0;
            c_d.txsh   = tx_block_i;
            c_d.sdo    = tx_block_i[0];
        end else begin
            unique case (c_q.state)
                ST_ARMED: begin
                    c_d.txsh = tx_block_i;
                    c_d.sdo  = tx_block_i[0];
                end
                ST_ACTIVE: begin
                    if (rise_i) begin
                        c_d.rxsh[c_q.bitcnt[IDXW-1:0]] = sdi_i;
                        if (c_q.bitcnt == LAST) begin
                            c_d.rxout  = c_d.rxsh;
                            c_d.done   = 1'b1;
                            c_d.state  = ST_FULL;
                            c_d.bitcnt = FULLCNT;
                        end else begin
                            c_d.bitcnt = c_q.bitcnt + 1'b1;
                        end
                    end
                    if (fall_i) begin
                        c_d.sdo = c_q.txsh[c_q.bitcnt[IDXW-1:0]];
                    end
                end
                default: begin
                    // full block: serial clocks are discarded
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state  <= ST_ARMED;
            c_q.bitcnt <= '0;
            c_q.txsh   <= '0;
            c_q.rxsh   <= '0;
            c_q.rxout  <= '0;
            c_q.sdo    <= 1'b0;
            c_q.done   <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign sdo_o      = c_q.sdo;
    assign rx_block_o = c_q.rxout;
    assign done_o     = c_q.done;
    assign state_o    = c_q.state;
    assign bitcnt_o   = c_q.bitcnt;

endmodule

// File: rtl/blkser_slave.sv
module blkser_slave
    import blkser_pkg::*;
#(
    parameter int BYTES = 8,
    parameter int BITS  = 8,
    parameter int TMO_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_i,
    input  logic                  sdi_i,
    output logic                  sdo_o,
    input  logic [TMO_W-1:0]      tmo_limit_i,
    input  logic [BYTES*BITS-1:0] tx_block_i,
    output logic [BYTES*BITS-1:0] rx_block_o,
    output logic                  done_o
);

    localparam int CNTW = $clog2(BYTES*BITS) + 1;

    logic            sc_rise;
    logic            sc_fall;
    logic            sd_sync;
    logic            expired;
    blk_state_e      core_state;
    logic [CNTW-1:0] core_bitcnt;

    blkser_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk_i),
        .sdi_i  (sdi_i),
        .rise_o (sc_rise),
        .fall_o (sc_fall),
        .sdi_o  (sd_sync)
    );

    blkser_tmo #(.TMO_W(TMO_W)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (sc_rise | sc_fall),
        .limit_i   (tmo_limit_i),
        .expired_o (expired)
    );

    blkser_core #(.BYTES(BYTES), .BITS(BITS)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (sc_rise),
        .fall_i     (sc_fall),
        .sdi_i      (sd_sync),
        .expired_i  (expired),
        .tx_block_i (tx_block_i),
        .sdo_o      (sdo_o),
        .rx_block_o (rx_block_o),
        .done_o     (done_o),
        .state_o    (core_state),
        .bitcnt_o   (core_bitcnt)
    );

endmodule

// File: rtl/blkser_slave_chk.sv
module blkser_slave_chk
    import blkser_pkg::*;
#(
    parameter int NBITS = 64,
    parameter int CNTW  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rise,
    input logic             fall,
    input logic             expired,
    input blk_state_e       state,
    input logic [CNTW-1:0]  bitcnt,
    input logic             sdo,
    input logic [NBITS-1:0] rx_block,
    input logic             done
);

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == ST_FULL && bitcnt == CNTW'(NBITS)));

    assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rx_block));

    assert_full_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && !expired) |=> (state == ST_FULL && $stable(sdo) && !done));

    assert_arm_on_silence_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !rise) |=> (state == ST_ARMED));

    assert_sdo_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && !fall && !expired) |=> $stable(sdo));

    assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= CNTW'(NBITS));

endmodule

bind blkser_slave blkser_slave_chk #(
    .NBITS (BYTES*BITS),
    .CNTW  ($clog2(BYTES*BITS) + 1)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (sc_rise),
    .fall     (sc_fall),
    .expired  (expired),
    .state    (core_state),
    .bitcnt   (core_bitcnt),
    .sdo      (sdo_o),
    .rx_block (rx_block_o),
    .done     (done_o)
);

// File: tb/sim_blkser_slave.sv
`timescale 1ns/1ps
module sim_blkser_slave;

    localparam int HALF  = 4;
    localparam int LIMIT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b0;
    logic        sdi_i = 1'b0;
    logic        sdo_o;
    logic [15:0] tmo_limit_i = 16'(LIMIT);
    logic [63:0] tx_block_i = 64'h0;
    logic [63:0] rx_block_o;
    logic        done_o;

    int n_chk = 0;
    int n_fail = 0;
    int done_cnt = 0;
    int done_wide = 0;
    logic done_prev = 1'b0;

    always #2.5 clk = ~clk;

    blkser_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk_i),
        .sdi_i       (sdi_i),
        .sdo_o       (sdo_o),
        .tmo_limit_i (tmo_limit_i),
        .tx_block_i  (tx_block_i),
        .rx_block_o  (rx_block_o),
        .done_o      (done_o)
    );

    always @(posedge clk) begin
        if (done_o) done_cnt <= done_cnt + 1;
        if (done_o && done_prev) done_wide <= done_wide + 1;
        done_prev <= done_o;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one serial clock period; returns the slave bit seen before the rising edge
    task automatic clock_bit(input logic b, output logic so);
        @(negedge clk);
        so     = sdo_o;
        sdi_i  = b;
        sclk_i = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk_i = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] m, input int nbits, input int pause_at,
                        input int pause_len, output logic [63:0] got);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            logic so;
            if (i == pause_at) idle(pause_len);
            clock_bit(m[i], so);
            got[i] = so;
        end
        idle(6);
    endtask

    task automatic t_reset;
        tx_block_i = 64'hA5C3_0F1E_7788_9BCD;
        idle(8);
        check("R1 done after reset", {63'd0, done_o}, 64'd0);
        check("R1 rx after reset", rx_block_o, 64'd0);
        check("R1 sdo shows tx bit0", {63'd0, sdo_o}, {63'd0, tx_block_i[0]});
    endtask

    task automatic t_full_block;
        logic [63:0] m = 64'h0123_4567_89AB_CDEF;
        logic [63:0] got;
        int d0 = done_cnt;
        send(m, 64, -1, 0, got);
        check("R2 rx block", rx_block_o, m);
        check("R3 tx bits", got, tx_block_i);
        check("R4 one done", 64'(done_cnt - d0), 64'd1);
    endtask

    task automatic t_extra_clocks;
        logic [63:0] keep = rx_block_o;
        logic        s0 = sdo_o;
        logic [63:0] got;
        int d0 = done_cnt;
        send(64'hFFFF_FFFF_FFFF_FFFF, 8, -1, 0, got);
        check("R6 no done on extra clocks", 64'(done_cnt - d0), 64'd0);
        check("R6 rx unchanged", rx_block_o, keep);
        check("R6 sdo unchanged", got[7:0], {8{s0}});
        check("R5 rx held", rx_block_o, keep);
    endtask

    task automatic t_new_after_gap;
        logic [63:0] m = 64'hDEAD_BEEF_5A5A_1234;
        logic [63:0] got;
        int d0 = done_cnt;
        idle(LIMIT + 10);
        tx_block_i = 64'h8000_0000_0000_0001;
        idle(4);
        send(m, 64, -1, 0, got);
        check("R7 block after silence", rx_block_o, m);
        check("R7 tx after silence", got, 64'h8000_0000_0000_0001);
        check("R7 one done", 64'(done_cnt - d0), 64'd1);
    endtask

    task automatic t_short_pause;
        logic [63:0] m = 64'h1357_9BDF_2468_ACE0;
        logic [63:0] got;
        int d0 = done_cnt;
        idle(LIMIT + 10);
        tx_block_i = 64'hC0FF_EE00_1122_3344;
        idle(4);
        send(m, 64, 32, 8, got);
        check("R8 rx across short pause", rx_block_o, m);
        check("R8 tx across short pause", got, tx_block_i);
        check("R8 one done", 64'(done_cnt - d0), 64'd1);
    endtask

    task automatic t_partial;
        logic [63:0] keep;
        logic [63:0] m = 64'hFEDC_BA98_7654_3210;
        logic [63:0] got;
        int d0;
        idle(LIMIT + 10);
        keep = rx_block_o;
        d0 = done_cnt;
        send(64'h5555_5555_5555_5555, 23, -1, 0, got);
        idle(LIMIT + 10);
        check("R9 no done on partial", 64'(done_cnt - d0), 64'd0);
        check("R9 rx unchanged by partial", rx_block_o, keep);
        send(m, 64, -1, 0, got);
        check("R7 rx after restart", rx_block_o, m);
        check("R9 single done after restart", 64'(done_cnt - d0), 64'd1);
    endtask

    task automatic t_mid_reset;
        logic [63:0] m = 64'h0F0F_F0F0_3C3C_C3C3;
        logic [63:0] got;
        int d0;
        send(64'hAAAA_AAAA_AAAA_AAAA, 20, -1, 0, got);
        rst_n = 1'b0;
        idle(3);
        check("R1 rx cleared by reset", rx_block_o, 64'd0);
        rst_n = 1'b1;
        idle(8);
        d0 = done_cnt;
        send(m, 64, -1, 0, got);
        check("R1 block after mid reset", rx_block_o, m);
        check("R1 one done after reset", 64'(done_cnt - d0), 64'd1);
        check("R4 done never wider than one cycle", 64'(done_wide), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        t_reset();
        t_full_block();
        t_extra_clocks();
        t_new_after_gap();
        t_short_pause();
        t_partial();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule